// File: doc/BRIEF.md
# Chainable Loadable Binary Counter Stage

This block is one stage of a synchronous up-counter. Its count register is four bits wide by default and steps through the binary sequence modulo 2^WIDTH. An active-low master reset clears the count at once, without waiting for a clock edge. An active-low load input copies a preset word into the count on the next rising clock edge. When neither reset nor load is active, the stage counts up on a rising edge only if both of its count enables are high. If either enable is low, the stage holds its value.

The two enables do different jobs. `en_chain` is the enable that moves from one stage to the next: it gates both counting and the carry output. `en_local` gates only counting. The carry output is high when the count is all ones and `en_chain` is high, and `en_local` has no effect on it. A wide counter is built by feeding each stage's carry into the next stage's `en_chain`, and it can use lookahead by wiring a low stage's carry to the `en_local` inputs of all higher stages.

Top module: `casc_counter_stage`

## Requirements
- R1: While `rst_n` is low, `count` is 0 with no clock edge needed, whatever the other inputs are; `carry_out` is then 0.
- R2: With `rst_n` high and `load_n` low, the next rising edge puts `preset` into `count`, whatever `en_local` and `en_chain` are.
- R3: With `rst_n` and `load_n` high and both `en_local` and `en_chain` high, each rising edge adds 1 to `count`.
- R4: With `rst_n` and `load_n` high and either enable low, `count` keeps its value across rising edges.
- R5: Counting from the all-ones value (15 for WIDTH=4) gives 0 on the next edge.
- R6: `carry_out` is 1 exactly when `count` is all ones and `en_chain` is 1; `en_local` does not affect it.
- R7: A load has priority over counting: `load_n` low with both enables high loads `preset` and does not increment.
- R8: A load works from any current value, including the all-ones value, and `carry_out` then follows the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low master clear |
| load_n | input | 1 | Active-low synchronous load of `preset` |
| en_local | input | 1 | Count enable that does not gate the carry |
| en_chain | input | 1 | Count enable that also gates the carry |
| preset | input | WIDTH | Value to load |
| count | output | WIDTH | Current count |
| carry_out | output | 1 | High when count is all ones and `en_chain` is high |

## Verification
Load and count compete in the same cycle when `load_n` is low while both enables are high. The bench sets this up with the stage at 15 and at an ordinary value, and it passes only if the next edge gives the preset value and not the incremented one. The clear and a pending load also meet: the bench pulls `rst_n` low between edges while `load_n` is low and checks that `count` reads 0 before the edge and still reads 0 after it. The carry is checked at 15 with each enable held low in turn, which keeps its dependence on the enables apart from counting.

// File: rtl/casc_counter_pkg.sv
package casc_counter_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD  = 2'd0,
    STEP_INCR  = 2'd1,
    STEP_LOAD  = 2'd2
  } step_e;
endpackage

// File: rtl/casc_step_decode.sv
module casc_step_decode
  import casc_counter_pkg::*;
(
  input  logic  load_n,
  input  logic  en_local,
  input  logic  en_chain,
  output step_e step
);
  // Priority: load over increment over hold (reset is handled in the register).
  always_comb begin
    if (!load_n)                    step = STEP_LOAD;
    else if (en_local && en_chain)  step = STEP_INCR;
    else                            step = STEP_HOLD;
  end
endmodule

// File: rtl/casc_next_value.sv
module casc_next_value
  import casc_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  step_e            step,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] incremented;

  // Natural overflow of the WIDTH-bit add gives the modulo wrap.
  assign incremented = cur + ONE;

  always_comb begin
    unique case (step)
      STEP_LOAD: nxt = preset;
      STEP_INCR: nxt = incremented;
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/casc_carry_detect.sv
module casc_carry_detect #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             en_chain,
  output logic             carry_out
);
  logic [WIDTH-1:0] ones_prefix;

  // AND chain over the count bits, built bit by bit.
  for (genvar i = 0; i < WIDTH; i++) begin : g_and
    if (i == 0) begin : g_first
      assign ones_prefix[i] = cur[i];
    end else begin : g_rest
      assign ones_prefix[i] = ones_prefix[i-1] & cur[i];
    end
  end

  assign carry_out = ones_prefix[WIDTH-1] & en_chain;
endmodule

// File: rtl/casc_counter_stage.sv
module casc_counter_stage
  import casc_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic             en_local,
  input  logic             en_chain,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] count,
  output logic             carry_out
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

  step_e            step;
  logic [WIDTH-1:0] count_q;
  logic [WIDTH-1:0] count_d;
  logic             reg_en;

  casc_step_decode u_decode (
    .load_n   (load_n),
    .en_local (en_local),
    .en_chain (en_chain),
    .step     (step)
  );

  casc_next_value #(.WIDTH(WIDTH)) u_next (
    .step   (step),
    .cur    (count_q),
    .preset (preset),
    .nxt    (count_d)
  );

  casc_carry_detect #(.WIDTH(WIDTH)) u_carry (
    .cur       (count_q),
    .en_chain  (en_chain),
    .carry_out (carry_out)
  );

  // Explicit clock enable: the register only updates on load or increment.
  assign reg_en = (step != STEP_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (reg_en) count_q <= count_d;
  end

  assign count = count_q;

  // R1: clear dominates while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_clear_r1: assert (count == '0 && !carry_out)
        else $error("R1 clear not held");
    end
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> count == $past(preset));

  p_incr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && en_local && en_chain) |=> count == $past(count) + ONE);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !(en_local && en_chain)) |=> $stable(count));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && en_local && en_chain && count == ALL_ONES) |=> count == '0);

  p_carry_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |-> (en_chain && count == ALL_ONES));

  p_carry_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_chain && count == ALL_ONES) |-> carry_out);
endmodule

// File: tb/tb_casc_counter_stage.sv
module tb_casc_counter_stage;
  localparam int W = 4;

  logic         clk;
  logic         rst_n;
  logic         load_n;
  logic         en_local;
  logic         en_chain;
  logic [W-1:0] preset;
  logic [W-1:0] count;
  logic         carry_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  casc_counter_stage #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_local(en_local),
    .en_chain(en_chain), .preset(preset), .count(count), .carry_out(carry_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int actual, input int expected);
    n_checks++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_in(input logic ld, input logic el, input logic ec, input int p);
    load_n = ld; en_local = el; en_chain = ec; preset = W'(p);
  endtask

  task automatic t_reset_state();
    chk("R1 count in reset", count, 0);
    chk("R1 carry in reset", carry_out, 0);
  endtask

  task automatic t_load();
    set_in(0, 0, 0, 9); step();
    chk("R2 load enables low", count, 9);
    set_in(0, 1, 0, 3); step();
    chk("R2 load en_chain low", count, 3);
  endtask

  task automatic t_count();
    set_in(1, 1, 1, 0);
    for (int i = 4; i <= 6; i++) begin
      step();
      chk("R3 increment", count, i);
    end
  endtask

  task automatic t_hold();
    set_in(1, 0, 1, 0); step();
    chk("R4 hold en_local low", count, 6);
    set_in(1, 1, 0, 0); step();
    chk("R4 hold en_chain low", count, 6);
    set_in(1, 0, 0, 0); step();
    chk("R4 hold both low", count, 6);
  endtask

  task automatic t_wrap();
    set_in(0, 0, 0, 14); step();
    set_in(1, 1, 1, 0); step();
    chk("R5 reach 15", count, 15);
    chk("R6 carry at 15 counting", carry_out, 1);
    step();
    chk("R5 wrap to 0", count, 0);
    chk("R6 carry after wrap", carry_out, 0);
  endtask

  task automatic t_carry();
    set_in(0, 0, 0, 15); step();
    set_in(1, 0, 0, 0); #1;
    chk("R6 carry en_chain low", carry_out, 0);
    en_local = 1; #1;
    chk("R6 carry en_local only", carry_out, 0);
    en_local = 0; en_chain = 1; #1;
    chk("R6 carry en_chain only", carry_out, 1);
    step();
    chk("R4 held at 15", count, 15);
    set_in(0, 0, 1, 14); step();
    chk("R6 carry not at 15", carry_out, 0);
  endtask

  task automatic t_precedence();
    set_in(0, 0, 0, 15); step();
    set_in(0, 1, 1, 5); step();
    chk("R7 load over count from 15", count, 5);
    chk("R8 carry follows load", carry_out, 0);
    set_in(0, 1, 1, 10); step();
    chk("R7 load over count", count, 10);
    set_in(0, 1, 1, 15); step();
    chk("R8 load all ones", count, 15);
    chk("R8 carry after load", carry_out, 1);
  endtask

  task automatic t_async_clear();
    set_in(1, 1, 1, 0); step();
    #1; rst_n = 0; load_n = 0; preset = 4'd7; #1;
    chk("R1 clear before edge", count, 0);
    step();
    chk("R1 clear over load", count, 0);
    chk("R1 carry during clear", carry_out, 0);
    rst_n = 1; set_in(1, 1, 1, 0); step();
    chk("R3 count after clear", count, 1);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1; set_in(1, 0, 0, 0);
    #2 rst_n = 0;
    @(negedge clk);
    t_reset_state();
    rst_n = 1;
    t_load();
    t_count();
    t_hold();
    t_wrap();
    t_carry();
    t_precedence();
    t_async_clear();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule